// File: doc/BRIEF.md
# One-wire temperature sensor master

This block runs a single-drop one-wire digital thermometer on its own, with no host in the loop. It is clocked by a 1 MHz tick, so every timing count is in microseconds. It drives an open-drain pad through an output that is tied low, an output-enable and a line input. Without stopping, it issues a bus reset, checks for a presence pulse and writes the alarm thresholds and the resolution into the sensor. It then starts a temperature conversion, waits for it to finish, and reads the whole scratchpad back.

The result registers hold the temperature low and high bytes and the two threshold bytes read back from the sensor. They change only when a full read has completed and all three resets in that pass saw the sensor answer. A presence flag follows the most recent reset. The configuration inputs are taken as they are while the bytes are being written, so the logic around the block keeps them steady while a pass is running.

Top module: `ow_temp_master`

## Requirements
- R1: While `rst_ni` is low, `tsens_oe_o` is 0 and `presence_o`, `temp_lo_o`, `temp_hi_o`, `th_rb_o` and `tl_rb_o` are all 0.
- R2: A bus reset pulls the line low for exactly 512 cycles and then leaves it released for 512 cycles. The next low starts 1024 cycles after the reset started.
- R3: The line is sampled 100 cycles after a reset releases it. `presence_o` becomes 1 if the line was low at that sample and 0 if it was high.
- R4: Each write slot lasts 90 cycles. A 0 bit pulls the line low for 80 cycles and a 1 bit for 8 cycles. Slots within a byte, and bytes within a command, follow each other with no gap.
- R5: Each read slot pulls the line low for 2 cycles, samples the line 8 cycles after the slot starts, and lasts 90 cycles. One pass contains 72 read slots, which cover scratchpad bytes 0 to 8.
- R6: Each pass sends these bytes, least significant bit first: reset, 0xCC, 0x4E, `th_i`, `tl_i`, config byte; reset, 0xCC, 0x44; conversion wait; reset, 0xCC, 0xBE; then 72 read slots.
- R7: The config byte carries `res_i` in bits 6:5 and has every other bit set to 1.
- R8: The conversion wait keeps the line released for `T_CONV` cycles after the last slot of the 0x44 byte. The next reset therefore starts `T_SLOT + T_CONV` cycles after that slot started.
- R9: At the end of a pass in which all three resets saw presence, `temp_lo_o` takes scratchpad byte 0, `temp_hi_o` byte 1, `th_rb_o` byte 2 and `tl_rb_o` byte 3. Bytes are received least significant bit first.
- R10: At the end of a pass in which any reset saw no presence, the four data outputs keep their previous values.
- R11: `tsens_o` is always 0. The block affects the line only by asserting `tsens_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1 MHz tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tsens_o | output | 1 | Pad data output, always 0 |
| tsens_oe_o | output | 1 | Pad output enable; 1 pulls the line low |
| tsens_i | input | 1 | Line level read from the pad |
| res_i | input | 2 | Resolution code written into the config byte |
| th_i | input | 8 | High alarm threshold to write |
| tl_i | input | 8 | Low alarm threshold to write |
| presence_o | output | 1 | Presence seen at the most recent reset |
| temp_lo_o | output | 8 | Temperature low byte (scratchpad byte 0) |
| temp_hi_o | output | 8 | Temperature high byte (scratchpad byte 1) |
| th_rb_o | output | 8 | High threshold read back (scratchpad byte 2) |
| tl_rb_o | output | 8 | Low threshold read back (scratchpad byte 3) |

## Verification
The timing properties depend on only one thing outside the block: the line input must be released high by the pull-up whenever neither the block nor the sensor holds it low. The output-update properties depend on the presence flag reflecting the level the sensor shows during the release phase. The bench models a sensor that answers at fixed offsets inside the windows the block samples: presence from 30 to 150 cycles after release, a read 0 held for 40 cycles, and write bits sampled 30 cycles into each slot. It changes the configuration inputs and the modelled temperature only at a pass boundary, and it disconnects the sensor only during the low phase of the first reset, so every sample lands on a settled level.

// File: rtl/ow_pkg.sv
`timescale 1ns/1ps
package ow_pkg;
  typedef enum logic [1:0] {
    SLOT_RST  = 2'd0,
    SLOT_WR   = 2'd1,
    SLOT_RD   = 2'd2,
    SLOT_WAIT = 2'd3
  } slot_kind_e;

  localparam logic [7:0] CMD_SKIP  = 8'hCC;
  localparam logic [7:0] CMD_WRSP  = 8'h4E;
  localparam logic [7:0] CMD_CONV  = 8'h44;
  localparam logic [7:0] CMD_RDSP  = 8'hBE;
endpackage

// File: rtl/ow_slot_engine.sv
`timescale 1ns/1ps
module ow_slot_engine
  import ow_pkg::*;
#(
  parameter int unsigned T_RST_LOW = 512,
  parameter int unsigned T_RST_REL = 512,
  parameter int unsigned T_PRES    = 100,
  parameter int unsigned T_W0      = 80,
  parameter int unsigned T_W1      = 8,
  parameter int unsigned T_RD_LOW  = 2,
  parameter int unsigned T_RD_SMP  = 8,
  parameter int unsigned T_SLOT    = 90,
  parameter int unsigned T_CONV    = 750000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  slot_kind_e kind_i,
  input  logic       wbit_i,
  input  logic       line_i,
  output logic       ack_o,
  output logic       busy_o,
  output logic       drive_o,
  output logic       rd_vld_o,
  output logic       rd_bit_o,
  output logic       pres_vld_o,
  output logic       pres_o
);
  localparam int unsigned T_RST_ALL = T_RST_LOW + T_RST_REL;
  localparam int unsigned T_BIG     = (T_CONV > T_RST_ALL) ? T_CONV : T_RST_ALL;
  localparam int unsigned T_MAX     = (T_BIG > T_SLOT) ? T_BIG : T_SLOT;
  localparam int CW = $clog2(T_MAX + 1);
  typedef logic [CW-1:0] cnt_t;

  localparam cnt_t C_RST_END  = cnt_t'(T_RST_ALL - 1);
  localparam cnt_t C_RST_LOW  = cnt_t'(T_RST_LOW);
  localparam cnt_t C_PRES     = cnt_t'(T_RST_LOW + T_PRES);
  localparam cnt_t C_SLOT_END = cnt_t'(T_SLOT - 1);
  localparam cnt_t C_CONV_END = cnt_t'(T_CONV - 1);
  localparam cnt_t C_W0       = cnt_t'(T_W0);
  localparam cnt_t C_W1       = cnt_t'(T_W1);
  localparam cnt_t C_RD_LOW   = cnt_t'(T_RD_LOW);
  localparam cnt_t C_RD_SMP   = cnt_t'(T_RD_SMP);

  logic       busy_q;
  cnt_t       cnt_q;
  slot_kind_e kind_q;
  logic       wbit_q;
  cnt_t       end_cnt;
  logic       last, load;

  always_comb begin
    unique case (kind_q)
      SLOT_RST:  end_cnt = C_RST_END;
      SLOT_WAIT: end_cnt = C_CONV_END;
      default:   end_cnt = C_SLOT_END;
    endcase
  end

  assign last  = busy_q && (cnt_q == end_cnt);
  assign load  = req_i && (!busy_q || last);
  assign ack_o = load;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= SLOT_RST;
      wbit_q <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      kind_q <= kind_i;
      wbit_q <= wbit_i;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + cnt_t'(1);
    end
  end

  always_comb begin
    drive_o = 1'b0;
    if (busy_q) begin
      unique case (kind_q)
        SLOT_RST: drive_o = (cnt_q < C_RST_LOW);
        SLOT_WR:  drive_o = (cnt_q < (wbit_q ? C_W1 : C_W0));
        SLOT_RD:  drive_o = (cnt_q < C_RD_LOW);
        default:  drive_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o   <= 1'b0;
      rd_bit_o   <= 1'b0;
      pres_vld_o <= 1'b0;
      pres_o     <= 1'b0;
    end else begin
      rd_vld_o   <= busy_q && (kind_q == SLOT_RD) && (cnt_q == C_RD_SMP);
      rd_bit_o   <= line_i;
      pres_vld_o <= busy_q && (kind_q == SLOT_RST) && (cnt_q == C_PRES);
      pres_o     <= !line_i;
    end
  end
endmodule

// File: rtl/ow_cmd_seq.sv
`timescale 1ns/1ps
module ow_cmd_seq
  import ow_pkg::*;
#(
  parameter int unsigned RD_BITS = 72
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  logic       busy_i,
  input  logic [1:0] res_i,
  input  logic [7:0] th_i,
  input  logic [7:0] tl_i,
  output logic       req_o,
  output slot_kind_e kind_o,
  output logic       wbit_o,
  output logic       commit_o
);
  localparam int BW = $clog2(RD_BITS);
  typedef logic [BW-1:0] bit_t;
  localparam bit_t B_BYTE_END = bit_t'(7);
  localparam bit_t B_RD_END   = bit_t'(RD_BITS - 1);

  localparam logic [3:0] S_RST0 = 4'd0,  S_SKIP0 = 4'd1,  S_WRSP = 4'd2;
  localparam logic [3:0] S_TH   = 4'd3,  S_TL    = 4'd4,  S_CFG  = 4'd5;
  localparam logic [3:0] S_RST1 = 4'd6,  S_SKIP1 = 4'd7,  S_CONV = 4'd8;
  localparam logic [3:0] S_WAIT = 4'd9,  S_RST2  = 4'd10, S_SKIP2 = 4'd11;
  localparam logic [3:0] S_RDSP = 4'd12, S_READ  = 4'd13, S_DONE = 4'd14;

  logic [3:0] step_q;
  bit_t       bit_q;
  logic [7:0] byte_v;
  logic       step_end;
  logic       commit_q;

  always_comb begin
    req_o  = 1'b1;
    kind_o = SLOT_WR;
    byte_v = 8'h00;
    unique case (step_q)
      S_RST0, S_RST1, S_RST2:    kind_o = SLOT_RST;
      S_SKIP0, S_SKIP1, S_SKIP2: byte_v = CMD_SKIP;
      S_WRSP:                    byte_v = CMD_WRSP;
      S_TH:                      byte_v = th_i;
      S_TL:                      byte_v = tl_i;
      S_CFG:                     byte_v = {1'b1, res_i, 5'b11111};
      S_CONV:                    byte_v = CMD_CONV;
      S_RDSP:                    byte_v = CMD_RDSP;
      S_WAIT:                    kind_o = SLOT_WAIT;
      S_READ:                    kind_o = SLOT_RD;
      default:                   req_o  = 1'b0;
    endcase
  end

  // LSB first
  assign wbit_o = (kind_o == SLOT_WR) && byte_v[bit_q[2:0]];

  always_comb begin
    unique case (kind_o)
      SLOT_WR: step_end = (bit_q == B_BYTE_END);
      SLOT_RD: step_end = (bit_q == B_RD_END);
      default: step_end = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= S_RST0;
      bit_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= (step_q == S_DONE) && !busy_i;
      if (step_q == S_DONE) begin
        if (!busy_i) step_q <= S_RST0;
      end else if (ack_i) begin
        if (step_end) begin
          step_q <= step_q + 4'd1;
          bit_q  <= '0;
        end else begin
          bit_q <= bit_q + bit_t'(1);
        end
      end
    end
  end

  assign commit_o = commit_q;
endmodule

// File: rtl/ow_sp_capture.sv
`timescale 1ns/1ps
module ow_sp_capture #(
  parameter int unsigned SP_BYTES = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_vld_i,
  input  logic       rd_bit_i,
  input  logic       pres_vld_i,
  input  logic       pres_i,
  input  logic       commit_i,
  output logic       presence_o,
  output logic [7:0] temp_lo_o,
  output logic [7:0] temp_hi_o,
  output logic [7:0] th_rb_o,
  output logic [7:0] tl_rb_o
);
  localparam int unsigned SP_BITS = 8 * SP_BYTES;

  logic [SP_BITS-1:0] sr_q;
  logic               ok_q;

  // bits arrive LSB first, byte 0 first: shift in at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (rd_vld_i) sr_q <= {rd_bit_i, sr_q[SP_BITS-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q       <= 1'b1;
      presence_o <= 1'b0;
      temp_lo_o  <= '0;
      temp_hi_o  <= '0;
      th_rb_o    <= '0;
      tl_rb_o    <= '0;
    end else begin
      if (pres_vld_i) begin
        presence_o <= pres_i;
        if (!pres_i) ok_q <= 1'b0;
      end
      if (commit_i) begin
        ok_q <= 1'b1;
        if (ok_q) begin
          temp_lo_o <= sr_q[7:0];
          temp_hi_o <= sr_q[15:8];
          th_rb_o   <= sr_q[23:16];
          tl_rb_o   <= sr_q[31:24];
        end
      end
    end
  end
endmodule

// File: rtl/ow_temp_master.sv
`timescale 1ns/1ps
module ow_temp_master
  import ow_pkg::*;
#(
  parameter int unsigned T_RST_LOW = 512,
  parameter int unsigned T_RST_REL = 512,
  parameter int unsigned T_PRES    = 100,
  parameter int unsigned T_W0      = 80,
  parameter int unsigned T_W1      = 8,
  parameter int unsigned T_RD_LOW  = 2,
  parameter int unsigned T_RD_SMP  = 8,
  parameter int unsigned T_SLOT    = 90,
  parameter int unsigned T_CONV    = 750000,
  parameter int unsigned SP_BYTES  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       tsens_o,
  output logic       tsens_oe_o,
  input  logic       tsens_i,
  input  logic [1:0] res_i,
  input  logic [7:0] th_i,
  input  logic [7:0] tl_i,
  output logic       presence_o,
  output logic [7:0] temp_lo_o,
  output logic [7:0] temp_hi_o,
  output logic [7:0] th_rb_o,
  output logic [7:0] tl_rb_o
);
  localparam int unsigned RD_BITS = 8 * SP_BYTES;

  logic       req, ack, busy, wbit, commit;
  logic       rd_vld, rd_bit, pres_vld, pres;
  slot_kind_e kind;

  ow_cmd_seq #(.RD_BITS(RD_BITS)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack), .busy_i(busy),
    .res_i(res_i), .th_i(th_i), .tl_i(tl_i),
    .req_o(req), .kind_o(kind), .wbit_o(wbit), .commit_o(commit)
  );

  ow_slot_engine #(
    .T_RST_LOW(T_RST_LOW), .T_RST_REL(T_RST_REL), .T_PRES(T_PRES),
    .T_W0(T_W0), .T_W1(T_W1), .T_RD_LOW(T_RD_LOW), .T_RD_SMP(T_RD_SMP),
    .T_SLOT(T_SLOT), .T_CONV(T_CONV)
  ) eng_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .kind_i(kind),
    .wbit_i(wbit), .line_i(tsens_i), .ack_o(ack), .busy_o(busy),
    .drive_o(tsens_oe_o), .rd_vld_o(rd_vld), .rd_bit_o(rd_bit),
    .pres_vld_o(pres_vld), .pres_o(pres)
  );

  ow_sp_capture #(.SP_BYTES(SP_BYTES)) cap_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_vld_i(rd_vld), .rd_bit_i(rd_bit),
    .pres_vld_i(pres_vld), .pres_i(pres), .commit_i(commit),
    .presence_o(presence_o), .temp_lo_o(temp_lo_o), .temp_hi_o(temp_hi_o),
    .th_rb_o(th_rb_o), .tl_rb_o(tl_rb_o)
  );

  // open drain: the pad is only ever pulled low
  assign tsens_o = 1'b0;
endmodule

// File: rtl/ow_temp_master_chk.sv
`timescale 1ns/1ps
module ow_temp_master_chk #(
  parameter int unsigned T_RST_LOW = 512,
  parameter int unsigned T_RST_REL = 512,
  parameter int unsigned T_W0      = 80,
  parameter int unsigned T_W1      = 8,
  parameter int unsigned T_RD_LOW  = 2,
  parameter int unsigned T_SLOT    = 90
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oe_i,
  input logic       presence_i,
  input logic [7:0] temp_lo_i,
  input logic [7:0] temp_hi_i
);
  logic [31:0] lo_run, hi_run, prev_low;
  logic        prev_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run   <= '0;
      hi_run   <= '0;
      prev_low <= '0;
      prev_vld <= 1'b0;
    end else begin
      lo_run <= oe_i ? lo_run + 32'd1 : 32'd0;
      hi_run <= oe_i ? 32'd0 : hi_run + 32'd1;
      if (!oe_i && lo_run != 32'd0) begin
        prev_low <= lo_run;
        prev_vld <= 1'b1;
      end
    end
  end

  // R2 R4 R5
  low_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_i) |-> (lo_run == T_RST_LOW || lo_run == T_W0 ||
                     lo_run == T_W1 || lo_run == T_RD_LOW));

  // R2
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_i) && prev_vld && prev_low == T_RST_LOW) |-> hi_run >= T_RST_REL);

  // R4
  slot_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_i) && prev_vld && prev_low != T_RST_LOW) |-> (prev_low + hi_run) >= T_SLOT);

  // R3
  presence_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(presence_i) |-> !$past(oe_i));

  // R9
  data_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(temp_lo_i) || !$stable(temp_hi_i)) |-> (!$past(oe_i) && presence_i));
endmodule

bind ow_temp_master ow_temp_master_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_i(tsens_oe_o), .presence_i(presence_o),
  .temp_lo_i(temp_lo_o), .temp_hi_i(temp_hi_o)
);

// File: tb/ow_temp_master_tb_top.sv
`timescale 1ns/1ps
module ow_temp_master_tb_top;
  localparam int CLK_PERIOD = 1000;
  localparam int CONV_W     = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] res;
  logic [7:0] th, tl;
  logic tsens_o_w, oe_w, presence;
  logic [7:0] t_lo, t_hi, th_rb, tl_rb;
  bit   slave_pull = 1'b0;
  wire  line_w = !(oe_w && !tsens_o_w) && !slave_pull;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_temp_master #(.T_CONV(CONV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tsens_o(tsens_o_w), .tsens_oe_o(oe_w),
    .tsens_i(line_w), .res_i(res), .th_i(th), .tl_i(tl),
    .presence_o(presence), .temp_lo_o(t_lo), .temp_hi_o(t_hi),
    .th_rb_o(th_rb), .tl_rb_o(tl_rb)
  );

  // ---------------- bus monitor and sensor model ----------------
  bit        slave_en = 1'b1;
  logic [15:0] model_temp = 16'h0000;
  logic [7:0]  sp [0:8];
  logic [7:0]  log_b [0:15];
  int log_n = 0;
  int cyc = 0, low_cnt = 0, n_rst = 0, n_fall = 0, last_fall = 0;
  int bad_low = 0, n_rd_low = 0, n_wr_low = 0, n_rst_low = 0;
  int min_gap = 1000000, rst_gap_bad = 0, conv_gap = 0, hi_drive = 0;
  bit conv_pend = 0, last_slot = 0, last_rst = 0, ml_d = 0;
  int pull_cnt = 0, pres_cnt = 0, samp_cnt = 0, tx_idx = 0;
  int ph = 0, rx_n = 0, wk = 0;
  logic [7:0] rx = 8'h00;

  initial begin
    sp[0] = 8'h00; sp[1] = 8'h00; sp[2] = 8'h00; sp[3] = 8'h00; sp[4] = 8'h00;
    sp[5] = 8'hFF; sp[6] = 8'h0C; sp[7] = 8'h10; sp[8] = 8'h5A;
  end

  task automatic take_byte();
    log_b[log_n & 15] = rx;
    log_n++;
    case (ph)
      1: ph = (rx == 8'hCC) ? 2 : 0;
      2: begin
        if (rx == 8'h4E) begin ph = 3; wk = 0; end
        else if (rx == 8'h44) begin
          sp[0] = model_temp[7:0]; sp[1] = model_temp[15:8];
          conv_pend = 1; ph = 0;
        end else if (rx == 8'hBE) begin ph = 4; tx_idx = 0; end
        else ph = 0;
      end
      3: begin sp[2+wk] = rx; wk++; if (wk == 3) ph = 0; end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    bit ml;
    ml = oe_w;
    cyc++;
    if (tsens_o_w) hi_drive++;
    if (pull_cnt > 0) pull_cnt--;
    if (pres_cnt > 0) begin pres_cnt++; if (pres_cnt > 200) pres_cnt = 0; end
    if (samp_cnt > 0) begin
      samp_cnt--;
      if (samp_cnt == 0) begin
        rx = {!ml, rx[7:1]};
        rx_n++;
        if (rx_n == 8) begin rx_n = 0; take_byte(); end
      end
    end
    if (ml) begin
      low_cnt++;
      if (!ml_d) begin
        n_fall++;
        if (last_slot && (cyc - last_fall) < min_gap) min_gap = cyc - last_fall;
        if (last_rst && (cyc - last_fall) != 1024) rst_gap_bad++;
        if (conv_pend) begin conv_gap = cyc - last_fall; conv_pend = 0; end
        last_fall = cyc;
        if (slave_en) begin
          if (ph == 4 && tx_idx < 72) begin
            if (!sp[tx_idx/8][tx_idx%8]) pull_cnt = 40;
            tx_idx++;
          end else if (ph != 4) samp_cnt = 30;
        end
      end
    end else if (ml_d) begin
      last_slot = 0; last_rst = 0;
      case (low_cnt)
        512: begin n_rst++; n_rst_low++; last_rst = 1; end
        80, 8: begin n_wr_low++; last_slot = 1; end
        2: begin n_rd_low++; last_slot = 1; end
        default: bad_low++;
      endcase
      if (low_cnt >= 480 && slave_en) begin
        ph = 1; rx_n = 0; samp_cnt = 0; pres_cnt = 1;
      end
      low_cnt = 0;
    end
    ml_d = ml;
    slave_pull = slave_en && (pull_cnt > 0 || (pres_cnt > 30 && pres_cnt <= 150));
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    log_n = 0; bad_low = 0; n_rd_low = 0; n_wr_low = 0; n_rst_low = 0;
    min_gap = 1000000; rst_gap_bad = 0; conv_gap = 0;
  endtask

  task automatic run_pass();
    int r0, f0;
    clear_stats();
    r0 = n_rst;
    wait (n_rst == r0 + 3);
    f0 = n_fall;
    wait (n_fall == f0 + 88);
    repeat (150) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1", "oe", oe_w, 0);
    chk("R1", "presence", presence, 0);
    chk("R1", "temp_lo", t_lo, 0);
    chk("R1", "temp_hi", t_hi, 0);
    chk("R1", "th_rb", th_rb, 0);
    chk("R1", "tl_rb", tl_rb, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_pass_present(logic [1:0] r, logic [7:0] h, logic [7:0] l, logic [15:0] t);
    logic [7:0] cfg;
    res = r; th = h; tl = l; model_temp = t;
    cfg = {1'b1, r, 5'b11111};
    run_pass();
    chk("R2", "reset lows", n_rst_low, 3);
    chk("R2", "reset to next slot", rst_gap_bad, 0);
    chk("R3", "presence", presence, 1);
    chk("R4", "write lows", n_wr_low, 72);
    chk("R4", "odd low widths", bad_low, 0);
    chk("R4", "min slot spacing", min_gap, 90);
    chk("R5", "read lows", n_rd_low, 72);
    chk("R6", "bytes seen", log_n, 9);
    chk("R6", "byte0 skip", log_b[0], 8'hCC);
    chk("R6", "byte1 wrsp", log_b[1], 8'h4E);
    chk("R6", "byte2 th", log_b[2], h);
    chk("R6", "byte3 tl", log_b[3], l);
    chk("R7", "config byte", log_b[4], cfg);
    chk("R6", "byte5 skip", log_b[5], 8'hCC);
    chk("R6", "byte6 conv", log_b[6], 8'h44);
    chk("R6", "byte7 skip", log_b[7], 8'hCC);
    chk("R6", "byte8 rdsp", log_b[8], 8'hBE);
    chk("R8", "conversion gap", conv_gap, 90 + CONV_W);
    chk("R9", "temp_lo", t_lo, t[7:0]);
    chk("R9", "temp_hi", t_hi, t[15:8]);
    chk("R9", "th_rb", th_rb, h);
    chk("R9", "tl_rb", tl_rb, l);
    chk("R11", "data pin driven high", hi_drive, 0);
  endtask

  task automatic t_pass_absent();
    logic [7:0] o_lo, o_hi, o_th, o_tl;
    o_lo = t_lo; o_hi = t_hi; o_th = th_rb; o_tl = tl_rb;
    slave_en = 1'b0;
    res = 2'b11; th = 8'h11; tl = 8'h22; model_temp = 16'h1234;
    run_pass();
    chk("R3", "presence absent", presence, 0);
    chk("R10", "temp_lo held", t_lo, o_lo);
    chk("R10", "temp_hi held", t_hi, o_hi);
    chk("R10", "th_rb held", th_rb, o_th);
    chk("R10", "tl_rb held", tl_rb, o_tl);
    chk("R5", "read lows absent", n_rd_low, 72);
    slave_en = 1'b1;
  endtask

  initial begin
    res = 2'b00; th = 8'h00; tl = 8'h00;
    t_reset_state();
    t_pass_present(2'b00, 8'h4B, 8'h05, 16'h0191);
    t_pass_present(2'b10, 8'hE2, 8'h7A, 16'hFE6F);
    t_pass_absent();
    t_pass_present(2'b01, 8'h33, 8'hC8, 16'h0550);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule